// File: doc/BRIEF.md
# Measurement Task Sequencer with Input Selection

This block runs the measurement loop of a sensor signal conditioner. It holds a small table of measurement slots. Each slot stores two 4-bit input codes, one for each leg of the differential input multiplexer, and a count register sets how many slots are active. When started, the block walks a fixed schedule over the active slots. For each slot it presents the two input codes, fires a conversion request at an ADC handshake, waits for the completion strobe, and passes the returned sample downstream tagged with the slot index.

Slots 0 and 1 are the main (bridge) slots, and they always open a round. Slots from 2 upward are auxiliary slots for temperature or diagnostic inputs. Main slot 0 is inserted between consecutive auxiliary slots, so the bridge is sampled often. Every slot is checked against the input-code rules all the time. A slot that breaks a rule shows an error flag and is skipped without any conversion. The table can be changed only while the sequencer is stopped.

Top module: `meas_task_seq`

## Requirements
- R1: After synchronous reset the block is idle: `busy`, `adc_start`, `res_valid` and every bit of `cfg_err` are low. Every slot holds positive code 0 and negative code 1, and the active count is 2.
- R2: A round with active count C visits slots in this order: 0, 1, then 2, 0, 3, 0, … up to slot C-1, with slot 0 between consecutive auxiliary slots. For C=4 the order is 0,1,2,0,3; for C=3 it is 0,1,2; for C=2 it is 0,1. After the last step the schedule wraps to step 0. A `go` pulse while idle starts at step 0.
- R3: A write to the active count stores values below 2 as 2 and values above the slot count (4) as 4.
- R4: Each conversion starts with `adc_start` high for exactly one cycle. `sel_pos`/`sel_neg` carry that slot's stored codes and stay unchanged until `adc_done`. Only one conversion is in flight at a time.
- R5: In the cycle after `adc_done` is sampled high, `res_valid` is high for one cycle, `res_data` equals the sampled `adc_result`, and `res_task` is the index of the slot that was converted.
- R6: Input code 9 is reserved. A slot using it on either leg raises its `cfg_err` bit and is skipped with no conversion.
- R7: Codes 6 and 7 (internal temperature) are legal only as a pair on one slot, as (6,7) or (7,6). Any other use of 6 or 7 raises the slot's `cfg_err` bit, and the slot is skipped.
- R8: Every other code combination is accepted without an error and driven unchanged. This includes the swapped bridge pair (positive 1, negative 0), which inverts polarity.
- R9: A `stop` asserted during a conversion lets that conversion finish and deliver its result. The block then goes idle and issues no further `adc_start`.
- R10: Writes to the slot table and to the active count while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start the schedule from step 0 (used only while idle) |
| stop | input | 1 | Request halt after the current conversion |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_slot | input | 2 | Slot index to write |
| cfg_pos | input | 4 | Positive-leg input code to write |
| cfg_neg | input | 4 | Negative-leg input code to write |
| cnt_we | input | 1 | Active count write strobe |
| cnt_val | input | 3 | Active count value to write (clamped) |
| adc_start | output | 1 | One-cycle conversion request |
| sel_pos | output | 4 | Positive-leg multiplexer code |
| sel_neg | output | 4 | Negative-leg multiplexer code |
| adc_done | input | 1 | Conversion complete strobe |
| adc_result | input | 18 | Conversion sample |
| res_valid | output | 1 | Tagged result strobe |
| res_data | output | 18 | Result sample |
| res_task | output | 2 | Slot index of the result |
| busy | output | 1 | Sequencer is running |
| cfg_err | output | 4 | Per-slot rule violation flags |

## Verification
The bench targets several corner cases, each with its likely failure.

- **Skipped slots next to the interleaved bridge slot.** A sequencer that launched a flagged slot, or lost its place in the schedule after a skip, would tag results with the wrong slot index.
- **Half-used temperature codes and the swapped bridge pair.** A checker that tested only for code 9, or that rejected the polarity swap, would show the wrong error vector.
- **Count writes outside the legal range.** A missing clamp would give a round length that does not match the bench's model.
- **A stop landing on the same edge as the completion strobe.** A wrong stop path would either drop the last result or launch one more conversion.
- **Table writes issued mid-run.** If those writes leaked through, they would change the driven codes and the error flags.

// File: rtl/mts_pkg.sv
package mts_pkg;

    localparam int CODE_W      = 4;
    localparam logic [CODE_W-1:0] CODE_RESERVED = 4'h9;
    localparam logic [CODE_W-1:0] CODE_TEMP_P   = 4'h6;
    localparam logic [CODE_W-1:0] CODE_TEMP_N   = 4'h7;
    localparam logic [CODE_W-1:0] CODE_BRIDGE_P = 4'h0;
    localparam logic [CODE_W-1:0] CODE_BRIDGE_N = 4'h1;
    localparam int MIN_ACTIVE  = 2;

    typedef struct packed {
        logic [CODE_W-1:0] pos;
        logic [CODE_W-1:0] neg;
    } chan_pair_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_t;

    function automatic logic is_temp(input logic [CODE_W-1:0] c);
        return (c == CODE_TEMP_P) || (c == CODE_TEMP_N);
    endfunction

    // Rule check for one slot: reserved code anywhere, or a lone temperature leg.
    function automatic logic pair_bad(input chan_pair_t p);
        logic rsvd;
        logic temp_any;
        logic temp_ok;
        rsvd     = (p.pos == CODE_RESERVED) || (p.neg == CODE_RESERVED);
        temp_any = is_temp(p.pos) || is_temp(p.neg);
        temp_ok  = ((p.pos == CODE_TEMP_P) && (p.neg == CODE_TEMP_N)) ||
                   ((p.pos == CODE_TEMP_N) && (p.neg == CODE_TEMP_P));
        return rsvd || (temp_any && !temp_ok);
    endfunction

endpackage

// File: rtl/mts_cfg.sv
module mts_cfg
    import mts_pkg::*;
#(
    parameter int N_SLOTS = 4,
    localparam int SLOT_W = $clog2(N_SLOTS),
    localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        busy,
    input  logic                        wr_en,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  chan_pair_t                  wr_pair,
    input  logic                        cnt_en,
    input  logic [CNT_W-1:0]            cnt_val,
    output chan_pair_t [N_SLOTS-1:0]    pairs,
    output logic [CNT_W-1:0]            cnt
);

    localparam logic [CNT_W-1:0] CNT_LO = CNT_W'(MIN_ACTIVE);
    localparam logic [CNT_W-1:0] CNT_HI = CNT_W'(N_SLOTS);

    chan_pair_t [N_SLOTS-1:0] pairs_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [CNT_W-1:0]         cnt_clamped;

    always_comb begin
        if (cnt_val < CNT_LO)      cnt_clamped = CNT_LO;
        else if (cnt_val > CNT_HI) cnt_clamped = CNT_HI;
        else                       cnt_clamped = cnt_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                pairs_q[i].pos <= CODE_BRIDGE_P;
                pairs_q[i].neg <= CODE_BRIDGE_N;
            end
            cnt_q <= CNT_LO;
        end else if (!busy) begin
            if (wr_en && (int'(wr_slot) < N_SLOTS))
                pairs_q[wr_slot] <= wr_pair;
            if (cnt_en)
                cnt_q <= cnt_clamped;
        end
    end

    assign pairs = pairs_q;
    assign cnt   = cnt_q;

    // R10: a write presented while running leaves the table untouched
    a_r10_table_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && (wr_en || cnt_en)) |=> ($stable(pairs_q) && $stable(cnt_q)));

    // R3: the stored count never leaves the legal range
    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= CNT_LO) && (cnt_q <= CNT_HI));

endmodule

// File: rtl/mts_chk.sv
module mts_chk
    import mts_pkg::*;
#(
    parameter int N_SLOTS = 4
) (
    input  chan_pair_t [N_SLOTS-1:0] pairs,
    output logic [N_SLOTS-1:0]       bad
);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign bad[g] = pair_bad(pairs[g]);
    end

endmodule

// File: rtl/mts_seq.sv
module mts_seq
    import mts_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int DATA_W  = 18,
    localparam int SLOT_W = $clog2(N_SLOTS),
    localparam int CNT_W  = $clog2(N_SLOTS + 1),
    localparam int STEP_W = $clog2(2 * N_SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go,
    input  logic                     stop,
    input  logic [CNT_W-1:0]         cnt,
    input  chan_pair_t [N_SLOTS-1:0] pairs,
    input  logic [N_SLOTS-1:0]       bad,
    input  logic                     adc_done,
    input  logic [DATA_W-1:0]        adc_result,
    output logic                     adc_start,
    output logic [CODE_W-1:0]        sel_pos,
    output logic [CODE_W-1:0]        sel_neg,
    output logic                     res_valid,
    output logic [DATA_W-1:0]        res_data,
    output logic [SLOT_W-1:0]        res_task,
    output logic                     busy
);

    seq_state_t          state_q;
    logic [STEP_W-1:0]   step_q;
    logic [STEP_W-1:0]   step_nxt;
    logic [SLOT_W-1:0]   cur_slot;
    logic [SLOT_W-1:0]   tag_q;
    logic                stop_pend_q;
    logic                stop_now;
    logic                adc_start_q;
    logic [CODE_W-1:0]   sel_pos_q;
    logic [CODE_W-1:0]   sel_neg_q;
    logic                res_valid_q;
    logic [DATA_W-1:0]   res_data_q;
    logic [SLOT_W-1:0]   res_task_q;

    // Steps per round: both mains, then each auxiliary with slot 0 between them.
    function automatic int round_len(input logic [CNT_W-1:0] c);
        return (int'(c) <= MIN_ACTIVE) ? MIN_ACTIVE : 2 * int'(c) - 3;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_at(input logic [STEP_W-1:0] s);
        int t;
        if (int'(s) < 2) return SLOT_W'(s);
        t = int'(s) - 2;
        if ((t % 2) == 1) return '0;
        return SLOT_W'(2 + t / 2);
    endfunction

    assign cur_slot = slot_at(step_q);
    assign step_nxt = (int'(step_q) + 1 >= round_len(cnt)) ? '0 : STEP_W'(int'(step_q) + 1);
    assign stop_now = stop || stop_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            step_q      <= '0;
            tag_q       <= '0;
            stop_pend_q <= 1'b0;
            adc_start_q <= 1'b0;
            sel_pos_q   <= '0;
            sel_neg_q   <= '0;
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
            res_task_q  <= '0;
        end else begin
            adc_start_q <= 1'b0;
            res_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    stop_pend_q <= 1'b0;
                    if (go) begin
                        step_q  <= '0;
                        state_q <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    if (stop) stop_pend_q <= 1'b1;
                    if (bad[cur_slot]) begin
                        step_q <= step_nxt;
                        if (stop_now) state_q <= ST_IDLE;
                    end else begin
                        adc_start_q <= 1'b1;
                        sel_pos_q   <= pairs[cur_slot].pos;
                        sel_neg_q   <= pairs[cur_slot].neg;
                        tag_q       <= cur_slot;
                        state_q     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (stop) stop_pend_q <= 1'b1;
                    if (adc_done) begin
                        res_valid_q <= 1'b1;
                        res_data_q  <= adc_result;
                        res_task_q  <= tag_q;
                        step_q      <= step_nxt;
                        state_q     <= stop_now ? ST_IDLE : ST_LAUNCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign adc_start = adc_start_q;
    assign sel_pos   = sel_pos_q;
    assign sel_neg   = sel_neg_q;
    assign res_valid = res_valid_q;
    assign res_data  = res_data_q;
    assign res_task  = res_task_q;
    assign busy      = (state_q != ST_IDLE);

    // R4: conversion request is a single-cycle pulse
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
        adc_start_q |=> !adc_start_q);

    // R4: codes stay put while the conversion is outstanding
    a_r4_codes_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !adc_done) |=> ($stable(sel_pos_q) && $stable(sel_neg_q)));

    // R6 / R7: a slot flagged by the rule checker is never converted
    a_r6_no_bad_launch: assert property (@(posedge clk) disable iff (rst)
        adc_start_q |-> !bad[tag_q]);

    // R5: a result only follows a sampled completion
    a_r5_result_after_done: assert property (@(posedge clk) disable iff (rst)
        res_valid_q |-> $past(adc_done));

    // R9: a completion with stop requested ends the run
    a_r9_stop_halts: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && adc_done && stop_now) |=> !busy);

endmodule

// File: rtl/meas_task_seq.sv
module meas_task_seq
    import mts_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int DATA_W  = 18,
    localparam int SLOT_W = $clog2(N_SLOTS),
    localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic                  stop,
    input  logic                  cfg_we,
    input  logic [SLOT_W-1:0]     cfg_slot,
    input  logic [CODE_W-1:0]     cfg_pos,
    input  logic [CODE_W-1:0]     cfg_neg,
    input  logic                  cnt_we,
    input  logic [CNT_W-1:0]      cnt_val,
    output logic                  adc_start,
    output logic [CODE_W-1:0]     sel_pos,
    output logic [CODE_W-1:0]     sel_neg,
    input  logic                  adc_done,
    input  logic [DATA_W-1:0]     adc_result,
    output logic                  res_valid,
    output logic [DATA_W-1:0]     res_data,
    output logic [SLOT_W-1:0]     res_task,
    output logic                  busy,
    output logic [N_SLOTS-1:0]    cfg_err
);

    chan_pair_t [N_SLOTS-1:0] pairs;
    chan_pair_t               wr_pair;
    logic [CNT_W-1:0]         cnt;
    logic [N_SLOTS-1:0]       bad;
    logic                     busy_i;

    assign wr_pair.pos = cfg_pos;
    assign wr_pair.neg = cfg_neg;

    mts_cfg #(.N_SLOTS(N_SLOTS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy_i),
        .wr_en   (cfg_we),
        .wr_slot (cfg_slot),
        .wr_pair (wr_pair),
        .cnt_en  (cnt_we),
        .cnt_val (cnt_val),
        .pairs   (pairs),
        .cnt     (cnt)
    );

    mts_chk #(.N_SLOTS(N_SLOTS)) u_chk (
        .pairs (pairs),
        .bad   (bad)
    );

    mts_seq #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .stop       (stop),
        .cnt        (cnt),
        .pairs      (pairs),
        .bad        (bad),
        .adc_done   (adc_done),
        .adc_result (adc_result),
        .adc_start  (adc_start),
        .sel_pos    (sel_pos),
        .sel_neg    (sel_neg),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_task   (res_task),
        .busy       (busy_i)
    );

    assign busy    = busy_i;
    assign cfg_err = bad;

endmodule

// File: tb/tb_meas_task_seq.sv
module tb_meas_task_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go = 1'b0, stop = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_slot = '0;
    logic [3:0]    cfg_pos = '0, cfg_neg = '0;
    logic          cnt_we = 1'b0;
    logic [2:0]    cnt_val = '0;
    logic          adc_start;
    logic [3:0]    sel_pos, sel_neg;
    logic          adc_done = 1'b0;
    logic [DW-1:0] adc_result = '0;
    logic          res_valid;
    logic [DW-1:0] res_data;
    logic [1:0]    res_task;
    logic          busy;
    logic [NS-1:0] cfg_err;

    int nchk = 0, nfail = 0;
    int nstart = 0, nres = 0;

    // bench mirror of the configuration
    logic [3:0] b_pos [NS];
    logic [3:0] b_neg [NS];
    int         b_cnt;
    int         b_step;

    // ADC model and expectation state
    bit         pending = 0;
    bit         prev_start = 0;
    int         lat = 0;
    int         exp_tag = 0;
    logic [3:0] exp_pos, exp_neg;
    logic [DW-1:0] exp_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    meas_task_seq dut (
        .clk(clk), .rst(rst), .go(go), .stop(stop),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_pos(cfg_pos), .cfg_neg(cfg_neg),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .adc_start(adc_start), .sel_pos(sel_pos), .sel_neg(sel_neg),
        .adc_done(adc_done), .adc_result(adc_result),
        .res_valid(res_valid), .res_data(res_data), .res_task(res_task),
        .busy(busy), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit b_bad(input logic [3:0] p, input logic [3:0] n);
        bit t_any, t_ok;
        t_any = (p == 4'h6) || (p == 4'h7) || (n == 4'h6) || (n == 4'h7);
        t_ok  = (p == 4'h6 && n == 4'h7) || (p == 4'h7 && n == 4'h6);
        return (p == 4'h9) || (n == 4'h9) || (t_any && !t_ok);
    endfunction

    function automatic int b_len();
        return (b_cnt <= 2) ? 2 : 2 * b_cnt - 3;
    endfunction

    function automatic int b_slot(input int s);
        if (s < 2) return s;
        if (((s - 2) % 2) == 1) return 0;
        return 2 + (s - 2) / 2;
    endfunction

    function automatic logic [NS-1:0] b_errs();
        logic [NS-1:0] e;
        for (int i = 0; i < NS; i++) e[i] = b_bad(b_pos[i], b_neg[i]);
        return e;
    endfunction

    function automatic int b_clamp(input int v);
        if (v < 2) return 2;
        if (v > NS) return NS;
        return v;
    endfunction

    // monitor + ADC responder, all at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            adc_done <= 1'b0;
            if (res_valid) begin
                nres++;
                chk(res_task == 2'(exp_tag), "R5", "result slot tag", int'(res_task), exp_tag);
                chk(res_data == exp_val, "R5", "result data", int'(res_data), int'(exp_val));
            end
            if (pending) begin
                chk(sel_pos == exp_pos && sel_neg == exp_neg, "R4", "codes held during conversion",
                    int'({sel_pos, sel_neg}), int'({exp_pos, exp_neg}));
                if (lat == 0) begin
                    exp_val = DW'($urandom);
                    adc_done   <= 1'b1;
                    adc_result <= exp_val;
                    pending = 0;
                end else begin
                    lat--;
                end
            end
            if (adc_start) begin
                int s;
                chk(!prev_start, "R4", "start longer than one cycle", 1, 0);
                chk(!pending, "R4", "overlapping conversion", 1, 0);
                s = 0;
                for (int k = 0; k < 16; k++) begin
                    s = b_slot(b_step);
                    b_step = (b_step + 1) % b_len();
                    if (!b_bad(b_pos[s], b_neg[s])) break;
                end
                exp_tag = s;
                exp_pos = b_pos[s];
                exp_neg = b_neg[s];
                chk(sel_pos == exp_pos && sel_neg == exp_neg, "R2", "scheduled slot codes",
                    int'({sel_pos, sel_neg}), int'({exp_pos, exp_neg}));
                pending = 1;
                lat = int'($urandom % 4);
                nstart++;
            end
            prev_start = adc_start;
        end
    end

    task automatic wr_slot(input int i, input logic [3:0] p, input logic [3:0] n);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_slot = 2'(i); cfg_pos = p; cfg_neg = n;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        b_pos[i] = p; b_neg[i] = n;
    endtask

    task automatic wr_cnt(input int v);
        @(posedge clk); #1;
        cnt_we = 1'b1; cnt_val = 3'(v);
        @(posedge clk); #1;
        cnt_we = 1'b0;
        b_cnt = b_clamp(v);
    endtask

    task automatic run(input int n, input bit poke);
        int base, w;
        logic [NS-1:0] err_before;
        base = nstart;
        err_before = cfg_err;
        b_step = 0;
        @(posedge clk); #1; go = 1'b1;
        @(posedge clk); #1; go = 1'b0;
        if (poke) begin
            w = 0;
            while (nstart < base + 2 && w < 5000) begin @(posedge clk); #1; w++; end
            cfg_we = 1'b1; cfg_slot = 2'd0; cfg_pos = 4'h9; cfg_neg = 4'h9;
            cnt_we = 1'b1; cnt_val = 3'd2;
            @(posedge clk); #1;
            cfg_we = 1'b0; cnt_we = 1'b0;
        end
        w = 0;
        while (nstart < base + n && w < 5000) begin @(posedge clk); #1; w++; end
        stop = 1'b1;
        @(posedge clk); #1; stop = 1'b0;
        w = 0;
        while (busy && w < 200) begin @(posedge clk); #1; w++; end
        repeat (8) @(posedge clk);
        #1;
        chk(nstart == base + n, "R9", "conversions started before halt", nstart - base, n);
        chk(nres == nstart, "R9", "last conversion delivered", nres, nstart);
        chk(!busy, "R9", "idle after stop", int'(busy), 0);
        if (poke)
            chk(cfg_err == err_before && cfg_err == b_errs(), "R10", "table unchanged by busy write",
                int'(cfg_err), int'(b_errs()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NS; i++) begin b_pos[i] = 4'h0; b_neg[i] = 4'h1; end
        b_cnt = 2; b_step = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !adc_start && !res_valid, "R1", "idle outputs after reset",
            int'({busy, adc_start, res_valid}), 0);
        chk(cfg_err == '0, "R1", "no errors after reset", int'(cfg_err), 0);

        // R1 reset table: count 2, bridge codes on both mains
        run(5, 0);

        // R8: swapped bridge, legal temperature pair, plain externals
        wr_cnt(4);
        wr_slot(0, 4'h0, 4'h1);
        wr_slot(1, 4'h1, 4'h0);
        wr_slot(2, 4'h6, 4'h7);
        wr_slot(3, 4'hB, 4'hD);
        #1 chk(cfg_err == '0, "R8", "legal pairs raise no error", int'(cfg_err), 0);
        run(11, 0);

        // R6: reserved code on slot 3, reversed temperature pair on slot 2
        wr_slot(3, 4'h9, 4'h3);
        wr_slot(2, 4'h7, 4'h6);
        #1 chk(cfg_err == 4'b1000, "R6", "reserved code flagged", int'(cfg_err), 8);
        run(8, 0);

        // R7: lone temperature leg on slot 2
        wr_slot(2, 4'h6, 4'hD);
        #1 chk(cfg_err == 4'b1100, "R7", "lone temperature code flagged", int'(cfg_err), 12);
        run(6, 0);

        // R3 clamp high, R10 writes during run
        wr_slot(2, 4'hA, 4'hD);
        wr_slot(3, 4'hC, 4'hD);
        wr_cnt(7);
        run(12, 1);

        // R3 clamp low, then count 3
        wr_cnt(0);
        run(5, 0);
        wr_cnt(3);
        run(7, 0);

        // random configurations
        for (int it = 0; it < 8; it++) begin
            for (int i = 0; i < NS; i++) begin
                logic [3:0] p, n;
                p = 4'($urandom); n = 4'($urandom);
                if ($urandom % 3 == 0) begin p = 4'h6; n = 4'h7; end
                if (i == 0 && b_bad(p, n)) begin p = 4'h0; n = 4'h1; end
                wr_slot(i, p, n);
            end
            wr_cnt(int'($urandom % 8));
            #1 chk(cfg_err == b_errs(), "R6", "random error vector (R7 rules too)",
                   int'(cfg_err), int'(b_errs()));
            run(6 + int'($urandom % 10), 0);
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule